// File: doc/BRIEF.md
# Read Prefetch Boundary Controller

This block sets the limit on how many DWORDs a bridge may prefetch for one read transaction, then follows the words as they are fetched and tells the master side when to stop. At a transaction start pulse it samples the read command class, whether the address lies in prefetchable space, the cache line size register, the flow-through mode flag and the start DWORD address. From these it computes one boundary address: the next address above the start that is aligned to the chosen block size.

After the start pulse, each fetched-word strobe advances an internal word pointer. The stop output rises in the same cycle that the last allowed word is counted. It also rises at once when the target disconnects, or when the initiator ends its frame during a flow-through transaction. Stop then stays high until the next start pulse. Words that arrive after stop are ignored.

Top module: `pfb_ctrl`

## Requirements
- R1: After reset, and before the first start pulse, stop_pf is 1 and bnd_addr is 0.
- R2: Configuration reads (rd_cmd=0) and I/O reads (rd_cmd=1) use a block of one DWORD, so bnd_addr = start_addr+1 and stop_pf rises on the first word. Flow-through mode does not change this.
- R3: A plain memory read (rd_cmd=2) with pref_space=0 uses a block of one DWORD.
- R4: A plain memory read with pref_space=1 uses a block of cls DWORDs when cls is 1, 2, 4 or 8, and a block of 16 DWORDs when cls is 0 or 16.
- R5: A memory read line (rd_cmd=3) uses the same block as R4 whatever the value of pref_space.
- R6: A memory read multiple (rd_cmd=4) uses a block of 2*cls DWORDs when cls is 1, 2, 4 or 8, and a block of 32 DWORDs when cls is 0 or 16. pref_space does not matter.
- R7: Any cls value outside {0,1,2,4,8,16} is treated as 0.
- R8: bnd_addr, valid from the cycle after the start pulse and held until the next start, equals floor(start_addr/B)*B + B modulo 2^ADDR_W, where B is the block size. A start address that is already aligned therefore gets a full block.
- R9: With flow_thru=1, a prefetching read (rd_cmd 2 with pref_space=1, or rd_cmd 3 or 4) uses a 1024-DWORD (4 KB) block.
- R10: With flow_thru sampled as 1, frame_off raises stop_pf in the same cycle. With flow_thru sampled as 0, frame_off has no effect.
- R11: tgt_disc raises stop_pf in the same cycle, before the boundary is reached.
- R12: stop_pf is 0 until the word that reaches bnd_addr, is 1 in that word's cycle, and stays 1 until the next start pulse. Words fetched after stop do not change bnd_addr or stop_pf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | One-cycle pulse that samples the transaction parameters |
| rd_cmd | input | 3 | Command class: 0 config, 1 I/O, 2 memory read, 3 read line, 4 read multiple |
| pref_space | input | 1 | Start address lies in prefetchable space |
| cls | input | 8 | Cache line size register, in DWORDs |
| flow_thru | input | 1 | Flow-through mode |
| start_addr | input | ADDR_W | DWORD address of the first word |
| word_fetched | input | 1 | One DWORD fetched this cycle |
| tgt_disc | input | 1 | Target disconnect |
| frame_off | input | 1 | Initiator deasserted its frame |
| stop_pf | output | 1 | Stop prefetching |
| bnd_addr | output | ADDR_W | Computed boundary DWORD address |

## Verification
The bench sweeps every command class against both space flags, both modes, every legal cache line size, several illegal ones, and start addresses that are aligned, one short of a 1 KB line, and misaligned. For each case it checks both the boundary and the exact word on which stop rises. Several kinds of error would show up here. A design that rounds an aligned start down to itself would report a zero-length window. Doubling the wrong command would give read line the multiple's block size. Letting illegal cache line sizes pass through would give odd, unaligned boundaries. Directed cases cover the remaining behaviour. A disconnect or a frame end must stop the fetch in the same cycle. Frame end must be ignored outside flow-through mode. Stop must not drop when words keep arriving after the limit.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [2:0] {
        CMD_CFG = 3'd0,
        CMD_IO  = 3'd1,
        CMD_MR  = 3'd2,
        CMD_MRL = 3'd3,
        CMD_MRM = 3'd4
    } rd_cmd_e;

    // log2 of the line-based block; illegal sizes fall back to 16 DWORDs
    function automatic logic [2:0] line_lg(input logic [7:0] cls);
        case (cls)
            8'd1:    line_lg = 3'd0;
            8'd2:    line_lg = 3'd1;
            8'd4:    line_lg = 3'd2;
            8'd8:    line_lg = 3'd3;
            default: line_lg = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pfb_limit.sv
module pfb_limit
    import pfb_pkg::*;
#(
    parameter int PAGE_LG = 10,
    parameter int LG_W    = 5
) (
    input  logic [2:0]      cmd,
    input  logic            pref,
    input  logic [7:0]      cls,
    input  logic            ft,
    output logic [LG_W-1:0] lg
);
    rd_cmd_e         c;
    logic [LG_W-1:0] line_sz;

    always_comb begin
        c       = rd_cmd_e'(cmd);
        line_sz = LG_W'(line_lg(cls));
        case (c)
            CMD_MR:  lg = !pref ? '0 : (ft ? LG_W'(PAGE_LG) : line_sz);
            CMD_MRL: lg = ft ? LG_W'(PAGE_LG) : line_sz;
            CMD_MRM: lg = ft ? LG_W'(PAGE_LG) : line_sz + LG_W'(1);
            default: lg = '0;
        endcase
    end

    always_comb begin
        // R9
        lg_range_chk: assert (lg <= LG_W'(PAGE_LG));
        // R2
        no_pf_chk: assert (!(cmd == 3'd0 || cmd == 3'd1) || lg == '0);
    end

endmodule

// File: rtl/pfb_align.sv
module pfb_align #(
    parameter int ADDR_W  = 30,
    parameter int PAGE_LG = 10,
    parameter int LG_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LG_W-1:0]   lg,
    output logic [ADDR_W-1:0] bnd
);
    logic [ADDR_W-1:0] cand [0:PAGE_LG];

    genvar g;
    generate
        for (g = 0; g <= PAGE_LG; g++) begin : g_cand
            assign cand[g] = ((addr >> g) + ADDR_W'(1)) << g;
        end
    endgenerate

    always_comb begin
        bnd = cand[0];
        for (int i = 1; i <= PAGE_LG; i++) begin
            if (lg == LG_W'(i)) bnd = cand[i];
        end
    end

    always_comb begin
        // R8
        nonzero_win_chk: assert ((bnd - addr) != '0);
    end

endmodule

// File: rtl/pfb_track.sv
module pfb_track #(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] bnd_in,
    input  logic              ft,
    input  logic              word,
    input  logic              tgt_disc,
    input  logic              frame_off,
    output logic              stop,
    output logic [ADDR_W-1:0] bnd_q
);
    logic [ADDR_W-1:0] ptr_q;
    logic              stop_q;
    logic              ft_q;
    logic              last_word;
    logic              stop_now;

    always_comb begin
        last_word = word && ((ptr_q + ADDR_W'(1)) == bnd_q);
        stop_now  = !stop_q && !start &&
                    (last_word || tgt_disc || (ft_q && frame_off));
        stop      = stop_q || stop_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b1;
            ptr_q  <= '0;
            bnd_q  <= '0;
            ft_q   <= 1'b0;
        end else if (start) begin
            stop_q <= 1'b0;
            ptr_q  <= start_addr;
            bnd_q  <= bnd_in;
            ft_q   <= ft;
        end else begin
            if (!stop_q && word) ptr_q <= ptr_q + ADDR_W'(1);
            if (stop_now)        stop_q <= 1'b1;
        end
    end

    // R12
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !start) |=> stop);
    // R8
    bnd_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(bnd_q));
    // R12
    stop_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_q) |-> $past(stop));
    // R12
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !stop_q |-> (ptr_q != bnd_q));

endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl #(
    parameter int ADDR_W  = 30,
    parameter int PAGE_LG = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic [2:0]        rd_cmd,
    input  logic              pref_space,
    input  logic [7:0]        cls,
    input  logic              flow_thru,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              word_fetched,
    input  logic              tgt_disc,
    input  logic              frame_off,
    output logic              stop_pf,
    output logic [ADDR_W-1:0] bnd_addr
);
    localparam int LG_W = $clog2(PAGE_LG + 1) + 1;

    logic [LG_W-1:0]   lg;
    logic [ADDR_W-1:0] bnd_next;

    pfb_limit #(.PAGE_LG(PAGE_LG), .LG_W(LG_W)) u_limit (
        .cmd  (rd_cmd),
        .pref (pref_space),
        .cls  (cls),
        .ft   (flow_thru),
        .lg   (lg)
    );

    pfb_align #(.ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG), .LG_W(LG_W)) u_align (
        .addr (start_addr),
        .lg   (lg),
        .bnd  (bnd_next)
    );

    pfb_track #(.ADDR_W(ADDR_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .start      (txn_start),
        .start_addr (start_addr),
        .bnd_in     (bnd_next),
        .ft         (flow_thru),
        .word       (word_fetched),
        .tgt_disc   (tgt_disc),
        .frame_off  (frame_off),
        .stop       (stop_pf),
        .bnd_q      (bnd_addr)
    );

endmodule

// File: tb/pfb_ctrl_tb.sv
module pfb_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 30;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              txn_start = 1'b0;
    logic [2:0]        rd_cmd = '0;
    logic              pref_space = 1'b0;
    logic [7:0]        cls = '0;
    logic              flow_thru = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              word_fetched = 1'b0;
    logic              tgt_disc = 1'b0;
    logic              frame_off = 1'b0;
    logic              stop_pf;
    logic [ADDR_W-1:0] bnd_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    pfb_ctrl #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .txn_start(txn_start), .rd_cmd(rd_cmd),
        .pref_space(pref_space), .cls(cls), .flow_thru(flow_thru),
        .start_addr(start_addr), .word_fetched(word_fetched),
        .tgt_disc(tgt_disc), .frame_off(frame_off),
        .stop_pf(stop_pf), .bnd_addr(bnd_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 200000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<200000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_block(int cmd, int pref, int c, int ft);
        int line;
        line = (c == 1 || c == 2 || c == 4 || c == 8) ? c : 16;
        case (cmd)
            2: return pref == 0 ? 1 : (ft != 0 ? 1024 : line);
            3: return ft != 0 ? 1024 : line;
            4: return ft != 0 ? 1024 : 2 * line;
            default: return 1;
        endcase
    endfunction

    task automatic begin_txn(int cmd, int pref, int c, int ft, int addr);
        @(negedge clk);
        rd_cmd = 3'(cmd); pref_space = 1'(pref); cls = 8'(c);
        flow_thru = 1'(ft); start_addr = ADDR_W'(addr); txn_start = 1'b1;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    // pulses words until stop is seen (same cycle), returns words counted
    task automatic run_words(int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            word_fetched = 1'b1;
            #1;
            n++;
            if (stop_pf) break;
        end
        @(negedge clk);
        word_fetched = 1'b0;
    endtask

    initial begin
        int n;
        int cls_set [9] = '{0, 1, 2, 4, 8, 16, 3, 32, 255};
        int addr_set [4] = '{'h3E0, 'h3F0, 'h3FD, 'hBFF};

        repeat (3) @(negedge clk);
        // R1
        chk(stop_pf == 1'b1, "R1 stop after reset", stop_pf, 1);
        chk(bnd_addr == '0, "R1 boundary after reset", bnd_addr, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(stop_pf == 1'b1, "R1 stop idle before start", stop_pf, 1);

        // sweep covering R2 R3 R4 R5 R6 R7 R8 R9 R12
        for (int cm = 0; cm < 5; cm++)
          for (int p = 0; p < 2; p++)
            for (int ci = 0; ci < 9; ci++)
              for (int f = 0; f < 2; f++)
                for (int ai = 0; ai < 4; ai++) begin
                    int b, a, eb, en;
                    a  = addr_set[ai];
                    b  = exp_block(cm, p, cls_set[ci], f);
                    eb = (a / b) * b + b;
                    en = eb - a;
                    begin_txn(cm, p, cls_set[ci], f, a);
                    chk(bnd_addr == ADDR_W'(eb), "R2-R9 sweep boundary (R8)", bnd_addr, eb);
                    run_words(en + 4, n);
                    chk(n == en, "R12 words until stop (R4 R5 R6 R7)", n, en);
                end

        // R9 aligned start in flow-through gets full 1024 block
        begin_txn(3, 0, 8, 1, 'h400);
        chk(bnd_addr == ADDR_W'('h800), "R9 4KB boundary", bnd_addr, 'h800);
        run_words(1100, n);
        chk(n == 1024, "R9 4KB word count", n, 1024);

        // R12 words after stop ignored
        begin_txn(2, 1, 4, 0, 'h10);
        run_words(10, n);
        repeat (3) begin
            @(negedge clk); word_fetched = 1'b1;
        end
        @(negedge clk); word_fetched = 1'b0; #1;
        chk(stop_pf == 1'b1, "R12 stop held after extra words", stop_pf, 1);
        chk(bnd_addr == ADDR_W'('h14), "R12 boundary held", bnd_addr, 'h14);

        // R11 target disconnect mid-burst
        begin_txn(4, 0, 0, 0, 'h3E0);
        run_words(3, n);
        chk(stop_pf == 1'b0, "R11 no stop before disconnect", stop_pf, 0);
        @(negedge clk); tgt_disc = 1'b1; #1;
        chk(stop_pf == 1'b1, "R11 stop same cycle as disconnect", stop_pf, 1);
        @(negedge clk); tgt_disc = 1'b0; #1;
        chk(stop_pf == 1'b1, "R11 stop held after disconnect", stop_pf, 1);

        // R10 frame end in flow-through stops
        begin_txn(3, 1, 0, 1, 'h0);
        run_words(5, n);
        @(negedge clk); frame_off = 1'b1; #1;
        chk(stop_pf == 1'b1, "R10 frame end stops in flow-through", stop_pf, 1);
        @(negedge clk); frame_off = 1'b0;

        // R10 frame end ignored outside flow-through
        begin_txn(3, 1, 0, 0, 'h3F0);
        @(negedge clk); frame_off = 1'b1; #1;
        chk(stop_pf == 1'b0, "R10 frame end ignored without flow-through", stop_pf, 0);
        @(negedge clk); frame_off = 1'b0;
        run_words(40, n);
        chk(n == 16, "R10 full count after ignored frame end", n, 16);

        // R2 I/O read in flow-through stays single DWORD
        begin_txn(1, 1, 16, 1, 'h400);
        chk(bnd_addr == ADDR_W'('h401), "R2 I/O boundary", bnd_addr, 'h401);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule